// File: doc/BRIEF.md
# Program Counter and Instruction Fetch

This block is the fetch front end of a small single-cycle processor. It keeps a 64-bit program counter that counts in bytes. On every enabled rising clock edge a dedicated adder moves it forward by four bytes. The counter's byte address is turned into a word index that selects one 32-bit word from a 256-entry read-only instruction store. That word is presented as the fetched instruction.

The store's contents are fixed when the block is built, through a module parameter, with a default of all zeros. The enable and clear pins act only at the D side of the counter register, and the clock is never gated. The instruction output has no handshake. It follows the counter combinationally within the same cycle, so the downstream logic takes it as a plain level.

Top module: `fetch_unit`

## Requirements
- R1: When `clr` is high at a rising edge, `pc` becomes 0 after that edge and `insn` shows store word 0.
- R2: When `clr` is low and `en` is high at a rising edge, `pc` becomes its previous value plus 4.
- R3: When `clr` and `en` are both low at a rising edge, `pc` keeps its previous value.
- R4: When `clr` and `en` are both high at the same edge, clear wins and `pc` becomes 0.
- R5: `insn` always equals the store word at index `pc[9:2]`, in the same cycle as `pc`.
- R6: When the counter passes byte address 1023, the word index wraps to 0 while `pc` keeps counting upward (for example, `pc` = 1024 fetches word 0). Bits of `pc` above bit 9 never change the word fetched.
- R7: The two low bits of `pc` are always 0 once the counter has been cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the counter register |
| clr | input | 1 | Synchronous clear of the counter; takes priority over `en` |
| en | input | 1 | Advance the counter by 4 at the next edge |
| pc | output | 64 | Current byte address held in the counter |
| insn | output | 32 | Instruction word fetched at `pc[9:2]` |

## Verification
Clear and advance can be requested at the same edge. The bench raises `clr` and `en` together, both once the counter has been running and again while it sits mid-store. It expects the counter to read 0 and the fetch to show word 0 after that edge, not address 4. Advance and wrap also coincide: the bench runs the counter through the 256-word boundary. It checks that the edge taking `pc` from 1020 to 1024 brings back word 0, while the full 64-bit value keeps growing. Every store word is made distinct so that a wrong index is always visible.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int unsigned ADDR_BITS_DFLT = 64;
  localparam int unsigned WORD_BITS_DFLT = 32;
  localparam int unsigned STORE_WORDS_DFLT = 256;
  localparam int unsigned STEP_BYTES_DFLT = 4;
endpackage

// File: rtl/pc_reg.sv
module pc_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] nxt;

  // enable and clear are selections at D; the clock runs free
  always_comb begin
    if (clr)     nxt = '0;
    else if (en) nxt = d;
    else         nxt = q_r;
  end

  always_ff @(posedge clk) q_r <= nxt;

  assign q = q_r;
endmodule

// File: rtl/pc_incr.sv
module pc_incr #(
  parameter int unsigned W    = 64,
  parameter int unsigned STEP = 4
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] sum
);
  assign sum = a + W'(STEP);
endmodule

// File: rtl/word_rom.sv
module word_rom #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter logic [DEPTH-1:0][DW-1:0] IMAGE = '0
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  assign data = IMAGE[addr];
endmodule

// File: rtl/fetch_unit.sv
module fetch_unit #(
  parameter int unsigned PC_W  = fetch_pkg::ADDR_BITS_DFLT,
  parameter int unsigned IW    = fetch_pkg::WORD_BITS_DFLT,
  parameter int unsigned DEPTH = fetch_pkg::STORE_WORDS_DFLT,
  parameter int unsigned STEP  = fetch_pkg::STEP_BYTES_DFLT,
  parameter logic [DEPTH-1:0][IW-1:0] ROM_IMAGE = '0
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            en,
  output logic [PC_W-1:0] pc,
  output logic [IW-1:0]   insn
);
  localparam int unsigned AW  = $clog2(DEPTH);
  localparam int unsigned OFS = $clog2(IW / 8);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_next;
  logic [AW-1:0]   widx;

  pc_reg #(.W(PC_W)) u_reg (
    .clk (clk),
    .clr (clr),
    .en  (en),
    .d   (pc_next),
    .q   (pc_q)
  );

  pc_incr #(.W(PC_W), .STEP(STEP)) u_inc (
    .a   (pc_q),
    .sum (pc_next)
  );

  // byte offset bits dropped; higher bits beyond the store ignored
  assign widx = pc_q[OFS +: AW];

  word_rom #(.DW(IW), .DEPTH(DEPTH), .AW(AW), .IMAGE(ROM_IMAGE)) u_rom (
    .addr (widx),
    .data (insn)
  );

  assign pc = pc_q;
endmodule

// File: rtl/fetch_unit_chk.sv
module fetch_unit_chk #(
  parameter int unsigned PC_W  = 64,
  parameter int unsigned IW    = 32,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned STEP  = 4,
  parameter logic [DEPTH-1:0][IW-1:0] ROM_IMAGE = '0
) (
  input logic            clk,
  input logic            clr,
  input logic            en,
  input logic [PC_W-1:0] pc,
  input logic [IW-1:0]   insn
);
  localparam int unsigned AW  = $clog2(DEPTH);
  localparam int unsigned OFS = $clog2(IW / 8);

  // R1 R4
  clear_to_zero_chk: assert property (@(posedge clk) clr |=> (pc == '0));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (clr)
    en |=> (pc == $past(pc) + PC_W'(STEP)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (clr)
    !en |=> $stable(pc));

  // R5 R6
  fetch_match_chk: assert property (@(posedge clk) disable iff (clr)
    insn == ROM_IMAGE[pc[OFS +: AW]]);

  // R7
  aligned_chk: assert property (@(posedge clk) disable iff (clr)
    pc[OFS-1:0] == '0);
endmodule

bind fetch_unit fetch_unit_chk #(
  .PC_W(PC_W), .IW(IW), .DEPTH(DEPTH), .STEP(STEP), .ROM_IMAGE(ROM_IMAGE)
) chk_i (
  .clk(clk), .clr(clr), .en(en), .pc(pc), .insn(insn)
);

// File: tb/fetch_unit_test.sv
`timescale 1ns/1ps
module fetch_unit_test;
  localparam int unsigned PC_W = 64;
  localparam int unsigned IW = 32;
  localparam int unsigned DEPTH = 256;

  function automatic logic [31:0] word_of(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {8'hC3, b, ~b, b ^ 8'h5A};
  endfunction

  function automatic logic [DEPTH*IW-1:0] build_image();
    logic [DEPTH*IW-1:0] v;
    v = '0;
    for (int i = 0; i < DEPTH; i++) v[i*IW +: IW] = word_of(i);
    return v;
  endfunction

  localparam logic [DEPTH*IW-1:0] IMG = build_image();

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic en  = 1'b0;
  logic [PC_W-1:0] pc;
  logic [IW-1:0] insn;

  int vectors = 0;
  int fails = 0;
  longint unsigned mpc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fetch_unit #(.ROM_IMAGE(IMG)) uut (
    .clk(clk), .clr(clr), .en(en), .pc(pc), .insn(insn)
  );

  task automatic step(input logic c, input logic e);
    string tag;
    logic [31:0] exp_w;
    @(negedge clk);
    clr = c;
    en = e;
    @(posedge clk);
    // reference model: clear beats advance
    if (c)      mpc = 0;
    else if (e) mpc = mpc + 4;
    #1;
    if (c && e)  tag = "R4";
    else if (c)  tag = "R1";
    else if (e)  tag = "R2";
    else         tag = "R3";
    vectors++;
    if (pc !== mpc) begin
      fails++;
      $display("FAIL %s pc actual=%0h expected=%0h", tag, pc, mpc);
    end
    exp_w = word_of(int'((mpc >> 2) % 256));
    vectors++;
    if (insn !== exp_w) begin
      fails++;
      $display("FAIL %s insn actual=%08h expected=%08h at pc=%0h",
               (mpc >= 1024) ? "R6" : "R5", insn, exp_w, mpc);
    end
    vectors++;
    if (pc[1:0] !== 2'b00) begin
      fails++;
      $display("FAIL R7 pc low bits actual=%0b expected=0", pc[1:0]);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    step(1, 0);                              // R1 reset state
    step(1, 0);
    for (int i = 0; i < 10; i++) step(0, 1); // R2 advance
    for (int i = 0; i < 3; i++) step(0, 0);  // R3 hold
    step(0, 1);
    step(1, 1);                              // R4 clear wins
    for (int i = 0; i < 5; i++) step(0, 1);
    step(0, 0);
    step(1, 1);                              // R4 again mid-run
    for (int i = 0; i < 300; i++) step(0, 1); // R6 wrap past 1023
    for (int i = 0; i < 40; i++) step(0, (i % 3) != 0); // R5 mixed pattern
    for (int i = 0; i < 260; i++) step(0, 1); // R6 second wrap
    step(1, 0);                              // R1 after long run
    step(0, 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule